// File: doc/BRIEF.md
# Gated Decade Frequency Meter

This block measures how often a slow external signal rises. It counts those rising edges during a gate window. The window is timed from a fixed reference clock. A prescaler and a chain of divide-by-ten stages produce tap pulses at three rates. A toggle register driven by the selected tap opens the gate for exactly one tap period and then keeps it closed for one tap period. The input is synchronized into the reference domain, and its rising edges are counted in a four-digit BCD counter while the gate is open.

When the gate closes, the count is copied into a display register. After a short wait, a timed clear returns the counter to zero, and a one-cycle strobe marks the end of the measurement. A decimal-point code goes out with the digits so that a display shows the frequency in the unit of the 1 s gate. Set the gate-select input while the gate is closed, then read the digits when the done strobe appears.

Top module: `fc_freq_meter`

## Requirements
- R1: While reset is held and afterwards until the first measurement ends, `bcd_o`, `dp_pos_o`, `ovf_o` and `done_o` are all zero.
- R2: The input is passed through two synchronizer flops and a rising-edge detector. A low-to-high change is counted only if it is detected while the gate is open. A held level adds nothing. A measurement of an input with a rise every P cycles reads the open length divided by P, within plus or minus one.
- R3: When a further edge arrives with the count at 9999, the count stays at 9999 and the overflow flag is set. The flag is presented with the digits: `ovf_o` high implies `bcd_o` is 16'h9999.
- R4: With tap index k, the gate is open for exactly BASE_DIV*10^k reference cycles. It opens on the edge after an edge number that is a multiple of BASE_DIV*10^k (edges counted from reset release). It closes one tap period later.
- R5: The gate select is captured when the gate opens. Changing `gate_sel` while the gate is open changes neither the gate length nor the reported decimal point of that measurement.
- R6: On the edge after the gate closes, the display register takes the final count, the overflow flag and the captured tap index. It holds them unchanged until the next gate close.
- R7: After the display update, the sequencer waits WAIT_CYC cycles and then clears the counter and overflow flag for CLR_CYC cycles. The clear is never active while the gate is open, and each measurement starts from 0000.
- R8: `done_o` is high for exactly one cycle, directly after the last clear cycle. For the gate that closes on edge g, `done_o` is high after edge g+1+WAIT_CYC+CLR_CYC.
- R9: `dp_pos_o` equals the tap index of the reported measurement. 0 (0.1 s gate) places the point one digit right of units. 1 (1 s gate) places it right of the units digit. 2 (10 s gate) places it between units and tens.
- R10: `bcd_o` carries units in bits [3:0], tens in [7:4], hundreds in [11:8] and thousands in [15:12], and every nibble is 0 to 9.
- R11: `gate_sel` code 3 (any code at or above N_TAPS) selects the slowest tap, the same as code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Conditioned, asynchronous signal to be measured |
| gate_sel | input | SEL_W (2) | Tap select: 0 short, 1 middle, 2 or 3 long gate |
| bcd_o | output | 4*N_DIGITS (16) | Latched BCD reading, units in the low nibble |
| dp_pos_o | output | SEL_W (2) | Decimal-point code of the latched reading |
| ovf_o | output | 1 | Latched saturation flag of the reading |
| done_o | output | 1 | One-cycle strobe at the end of each measurement |

## Verification
Most faults in the divider, the toggle register or the sequencer move the gate-close edge. Any such fault shows up as a `done_o` strobe at the wrong cycle, at the end of the first measurement. A count that slips by one edge, or a clear that starts too early, first shows up as a wrong `bcd_o` value at that same display update. A stale overflow flag or tap index shows up in the next reading rather than in the one that caused it. For that reason, the stimulus runs an overflowing measurement and follows it with a short one.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LATCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_CLEAR = 2'd3
  } fc_state_e;

  localparam int unsigned BCD_W = 4;
  localparam logic [BCD_W-1:0] BCD_MAX = 4'd9;

endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  // sh[SYNC_STAGES-1] is the last synchronizer flop, sh[SYNC_STAGES] its delayed copy
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], sig_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/fc_refdiv.sv
module fc_refdiv #(
  parameter  int BASE_DIV = 10000,
  parameter  int N_TAPS   = 3,
  localparam int PRE_W    = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [N_TAPS-1:0] tap_o
);
  import fc_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic             pre_wrap;
  logic             carry [N_TAPS];

  assign pre_wrap = (pre_q == PRE_W'(BASE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || pre_wrap) pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end

  assign carry[0] = pre_wrap;

  // synchronous decade cascade: stage k advances on the carry of stage k-1
  for (genvar k = 0; k < N_TAPS - 1; k++) begin : g_dec
    logic [BCD_W-1:0] dec_q;
    always_ff @(posedge clk) begin
      if (rst)           dec_q <= '0;
      else if (carry[k]) dec_q <= (dec_q == BCD_MAX) ? '0 : dec_q + 1'b1;
    end
    assign carry[k+1] = carry[k] & (dec_q == BCD_MAX);
  end

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    assign tap_o[k] = carry[k];
  end
endmodule

// File: rtl/fc_bcd_cnt.sv
module fc_bcd_cnt #(
  parameter  int N_DIGITS = 4,
  localparam int DW       = 4 * N_DIGITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [DW-1:0] cnt_o,
  output logic          ovf_o
);
  import fc_pkg::*;

  logic [N_DIGITS-1:0] at_max;
  logic                en [N_DIGITS+1];
  logic                full;

  assign full  = &at_max;
  assign en[0] = inc_i & ~full;

  for (genvar d = 0; d < N_DIGITS; d++) begin : g_dig
    logic [BCD_W-1:0] dig_q;
    assign at_max[d] = (dig_q == BCD_MAX);
    assign en[d+1]   = en[d] & at_max[d];
    assign cnt_o[4*d +: 4] = dig_q;
    always_ff @(posedge clk) begin
      if (rst || clr_i) dig_q <= '0;
      else if (en[d])   dig_q <= at_max[d] ? '0 : dig_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)       ovf_o <= 1'b0;
    else if (inc_i && full) ovf_o <= 1'b1;
  end
endmodule

// File: rtl/fc_seq.sv
module fc_seq #(
  parameter  int N_TAPS   = 3,
  parameter  int WAIT_CYC = 3,
  parameter  int CLR_CYC  = 1,
  localparam int SEL_W    = (N_TAPS > 1) ? $clog2(N_TAPS) : 1,
  localparam int WAIT_W   = $clog2(WAIT_CYC + 1),
  localparam int CLR_W    = $clog2(CLR_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              gate_o,
  output logic [SEL_W-1:0]  msel_o,
  output logic              latch_o,
  output logic              clr_o,
  output logic              done_o
);
  import fc_pkg::*;

  fc_state_e        state_q;
  logic             tick_q;
  logic             gate_q;
  logic [SEL_W-1:0] msel_q;
  logic [SEL_W-1:0] sel_live;
  logic [SEL_W-1:0] tap_idx;
  logic             close_evt;
  logic [WAIT_W-1:0] wcnt_q;
  logic [CLR_W-1:0]  ccnt_q;

  // codes beyond the last tap fall back to the slowest tap
  assign sel_live  = (int'(sel_i) >= N_TAPS) ? SEL_W'(N_TAPS - 1) : sel_i;
  assign tap_idx   = gate_q ? msel_q : sel_live;
  assign close_evt = tick_q & gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      gate_q <= 1'b0;
      msel_q <= '0;
    end else begin
      tick_q <= tap_i[tap_idx];
      if (tick_q) begin
        gate_q <= ~gate_q;
        if (!gate_q) msel_q <= sel_live;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      wcnt_q  <= '0;
      ccnt_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_RUN:   if (close_evt) state_q <= ST_LATCH;
        ST_LATCH: begin
          state_q <= ST_WAIT;
          wcnt_q  <= '0;
        end
        ST_WAIT: begin
          wcnt_q <= wcnt_q + 1'b1;
          if (wcnt_q == WAIT_W'(WAIT_CYC - 1)) begin
            state_q <= ST_CLEAR;
            ccnt_q  <= '0;
          end
        end
        ST_CLEAR: begin
          ccnt_q <= ccnt_q + 1'b1;
          if (ccnt_q == CLR_W'(CLR_CYC - 1)) begin
            state_q <= ST_RUN;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign gate_o  = gate_q;
  assign msel_o  = msel_q;
  assign latch_o = (state_q == ST_LATCH);
  assign clr_o   = (state_q == ST_CLEAR);
endmodule

// File: rtl/fc_freq_meter.sv
module fc_freq_meter #(
  parameter  int BASE_DIV    = 10000,
  parameter  int N_TAPS      = 3,
  parameter  int N_DIGITS    = 4,
  parameter  int WAIT_CYC    = 3,
  parameter  int CLR_CYC     = 1,
  parameter  int SYNC_STAGES = 2,
  localparam int SEL_W       = (N_TAPS > 1) ? $clog2(N_TAPS) : 1,
  localparam int DW          = 4 * N_DIGITS
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             sig_in,
  input  logic [SEL_W-1:0] gate_sel,
  output logic [DW-1:0]    bcd_o,
  output logic [SEL_W-1:0] dp_pos_o,
  output logic             ovf_o,
  output logic             done_o
);
  logic [N_TAPS-1:0] taps;
  logic              rise;
  logic              gate;
  logic [SEL_W-1:0]  msel;
  logic              latch;
  logic              clr;
  logic              inc;
  logic [DW-1:0]     cnt_val;
  logic              cnt_ovf;

  fc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst(rst), .sig_i(sig_in), .rise_o(rise)
  );

  fc_refdiv #(.BASE_DIV(BASE_DIV), .N_TAPS(N_TAPS)) u_div (
    .clk(clk_ref), .rst(rst), .tap_o(taps)
  );

  fc_seq #(.N_TAPS(N_TAPS), .WAIT_CYC(WAIT_CYC), .CLR_CYC(CLR_CYC)) u_seq (
    .clk(clk_ref), .rst(rst), .tap_i(taps), .sel_i(gate_sel),
    .gate_o(gate), .msel_o(msel), .latch_o(latch), .clr_o(clr), .done_o(done_o)
  );

  assign inc = rise & gate;

  fc_bcd_cnt #(.N_DIGITS(N_DIGITS)) u_cnt (
    .clk(clk_ref), .rst(rst), .clr_i(clr), .inc_i(inc),
    .cnt_o(cnt_val), .ovf_o(cnt_ovf)
  );

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      bcd_o    <= '0;
      dp_pos_o <= '0;
      ovf_o    <= 1'b0;
    end else if (latch) begin
      bcd_o    <= cnt_val;
      dp_pos_o <= msel;
      ovf_o    <= cnt_ovf;
    end
  end
endmodule

// File: rtl/fc_freq_meter_chk.sv
module fc_freq_meter_chk #(
  parameter  int N_DIGITS = 4,
  localparam int DW       = 4 * N_DIGITS
) (
  input logic          clk,
  input logic          rst,
  input logic          gate,
  input logic          clr,
  input logic          latch,
  input logic          done,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] disp,
  input logic          ovf
);
  function automatic logic all_bcd(input logic [DW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < N_DIGITS; d++) if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [DW-1:0] all_nines();
    logic [DW-1:0] v;
    for (int d = 0; d < N_DIGITS; d++) v[4*d +: 4] = 4'd9;
    return v;
  endfunction

  p_bcd_legal_r10: assert property (@(posedge clk) disable iff (rst) all_bcd(disp));
  p_sat_full_r3: assert property (@(posedge clk) disable iff (rst) ovf |-> disp == all_nines());
  p_count_frozen_r2: assert property (@(posedge clk) disable iff (rst) (!gate && !clr) |=> $stable(cnt));
  p_no_clear_in_gate_r7: assert property (@(posedge clk) disable iff (rst) gate |-> !clr);
  p_start_zero_r7: assert property (@(posedge clk) disable iff (rst) $fell(clr) |-> cnt == '0);
  p_disp_hold_r6: assert property (@(posedge clk) disable iff (rst) !latch |=> $stable(disp));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_after_clear_r8: assert property (@(posedge clk) disable iff (rst) done |-> $past(clr));
endmodule

bind fc_freq_meter fc_freq_meter_chk #(.N_DIGITS(N_DIGITS)) u_chk (
  .clk(clk_ref), .rst(rst), .gate(gate), .clr(clr), .latch(latch),
  .done(done_o), .cnt(cnt_val), .disp(bcd_o), .ovf(ovf_o)
);

// File: tb/sim_fc_freq_meter.sv
module sim_fc_freq_meter;
  localparam int CLK_PERIOD = 10;
  localparam int B  = 300;
  localparam int W  = 3;
  localparam int C  = 2;
  localparam int WD_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sig = 1'b0;
  logic [1:0]  sel = 2'd1;
  logic [15:0] bcd;
  logic [1:0]  dp;
  logic        ovf;
  logic        done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int hp    = 0;
  int hc    = 0;
  bit model_on = 0;

  fc_freq_meter #(.BASE_DIV(B), .WAIT_CYC(W), .CLR_CYC(C)) u0 (
    .clk_ref(clk), .rst(rst), .sig_in(sig), .gate_sel(sel),
    .bcd_o(bcd), .dp_pos_o(dp), .ovf_o(ovf), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int to_int(input logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic bit fires(input int n, input int k);
    int p = B;
    for (int i = 0; i < k; i++) p = p * 10;
    return (n > 0) && (n % p == 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // input generator: toggles every hp cycles, holds level when hp == 0
  always @(negedge clk) begin
    if (hp > 0) begin
      if (hc >= hp - 1) begin sig = ~sig; hc = 0; end
      else hc = hc + 1;
    end
  end

  // behavioural reference model, advanced on every edge
  int m_gate, m_tick, m_msel, m_cnt, m_ovf, m_s1, m_s2, m_s3, close_e;
  int e_val, e_dp, e_ovf, e_done;

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; m_gate = 0; m_tick = 0; m_msel = 0; m_cnt = 0; m_ovf = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; close_e = -1000000;
      e_val = 0; e_dp = 0; e_ovf = 0; e_done = 0;
    end else begin
      int k, lsel, nt;
      bit rise_in_gate, clearing;
      cyc = cyc + 1;
      lsel = (sel >= 2'd3) ? 2 : int'(sel);
      rise_in_gate = (m_gate != 0) && (m_s2 != 0) && (m_s3 == 0);
      clearing = (cyc >= close_e + 2 + W) && (cyc <= close_e + 1 + W + C);
      if (cyc == close_e + 1) begin
        e_val = m_cnt; e_ovf = m_ovf; e_dp = m_msel;
      end
      e_done = (cyc == close_e + 1 + W + C) ? 1 : 0;
      if (clearing) begin m_cnt = 0; m_ovf = 0; end
      else if (rise_in_gate) begin
        if (m_cnt == 9999) m_ovf = 1; else m_cnt = m_cnt + 1;
      end
      k  = (m_gate != 0) ? m_msel : lsel;
      nt = fires(cyc, k) ? 1 : 0;
      if (m_tick != 0) begin
        if (m_gate == 0) m_msel = lsel;
        else close_e = cyc;
        m_gate = (m_gate != 0) ? 0 : 1;
      end
      m_tick = nt;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(sig);
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(to_int(bcd) == e_val, "R6 display value", to_int(bcd), e_val);
      chk(int'(ovf) == e_ovf, "R3 overflow flag", int'(ovf), e_ovf);
      chk(int'(dp) == e_dp, "R9 decimal point", int'(dp), e_dp);
      chk(int'(done) == e_done, "R4 R8 done timing", int'(done), e_done);
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (done !== 1'b1);
    chk((bcd[3:0] <= 9) && (bcd[7:4] <= 9) && (bcd[11:8] <= 9) && (bcd[15:12] <= 9),
        "R10 nibble range", int'(bcd), 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    chk(1'b0, "watchdog", cyc, WD_LIMIT);
    finish_run();
  end

  initial begin
    int wait_to;
    hp = 3; sel = 2'd1;
    repeat (5) @(negedge clk);
    chk(bcd == 16'h0 && dp == 2'd0 && ovf == 1'b0 && done == 1'b0, "R1 reset state", int'(bcd), 0);
    rst = 1'b0;
    model_on = 1;
    @(negedge clk);
    chk(bcd == 16'h0 && done == 1'b0, "R1 after release", int'(bcd), 0);

    // middle gate, rise every 6 cycles: 3000/6 = 500
    wait_done();
    chk(cyc == 2*3000 + 1 + 1 + W + C, "R4 close and done cycle", cyc, 2*3000 + 1 + 1 + W + C);
    chk(to_int(bcd) >= 499 && to_int(bcd) <= 501, "R2 middle gate count", to_int(bcd), 500);
    chk(dp == 2'd1, "R9 middle gate point", int'(dp), 1);

    // short gate, rise every 2 cycles: 300/2 = 150
    sel = 2'd0; hp = 1;
    wait_done();
    chk(to_int(bcd) >= 149 && to_int(bcd) <= 151, "R2 short gate count", to_int(bcd), 150);
    chk(dp == 2'd0, "R9 short gate point", int'(dp), 0);

    // held level: no edges counted, count restarts from zero
    hp = 0; sig = 1'b1;
    wait_done();
    chk(to_int(bcd) == 0, "R2 R7 held input reads zero", to_int(bcd), 0);

    // select changed while the gate is open
    sel = 2'd1; hp = 3;
    wait_to = ((cyc / 3000) + 1) * 3000 + 1500;
    while (cyc < wait_to) @(negedge clk);
    sel = 2'd2;
    wait_done();
    chk(to_int(bcd) >= 499 && to_int(bcd) <= 501, "R5 count unaffected by select", to_int(bcd), 500);
    chk(dp == 2'd1, "R5 point unaffected by select", int'(dp), 1);

    // code 3 selects the long gate; 30000/2 = 15000 saturates
    sel = 2'd3; hp = 1;
    wait_done();
    chk(bcd == 16'h9999, "R3 saturated digits", to_int(bcd), 9999);
    chk(ovf == 1'b1, "R3 overflow latched", int'(ovf), 1);
    chk(dp == 2'd2, "R11 code 3 long gate point", int'(dp), 2);

    // next short measurement: flag and count cleared
    sel = 2'd0; hp = 2;
    wait_done();
    chk(ovf == 1'b0, "R7 overflow cleared", int'(ovf), 0);
    chk(to_int(bcd) >= 74 && to_int(bcd) <= 76, "R7 fresh count", to_int(bcd), 75);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule